// File: doc/BRIEF.md
# Oscillator Start-Stop Task Controller

This block sequences two clock sources, a fast one and a slow one, and a calibration request for the slow oscillator. Software drives it through a small word-addressed register file. A write of 1 to a one-shot task register starts or stops a source, or requests a calibration. Each source runs its own four-state machine. A programmable count of system clock cycles stands in for the oscillator wake-up time.

When a start completes, a status word is loaded and a started event flag is raised. When a stop is accepted, the status word is cleared at once. Event flags combine with an enable mask into one level interrupt. The mask has separate set and clear registers. Software clears a flag by writing 0 to it and can force a flag by writing 1.

Top module: `osc_task_ctrl`

## Requirements
- R1: After reset both machines read Stopped, run bits, status words, event flags and the enable mask are 0, the interrupt is low and the debounce register (address 22) reads 0x10.
- R2: A fast-source start task (address 0, data bit 0 = 1) is accepted only in Stopped or Stopping. It enters Starting and sets the fast run bit (address 16, bit 0). In Starting or Started it has no effect.
- R3: A start completes HF_START_CYC (fast) or LF_START_CYC (slow) cycles after the task edge. The state becomes Started and the status word (fast at 17, slow at 19) holds 1 in bit 0 and the source code in bits 17:16. The fast source code is 1. The matching started event is set (fast at 8, slow at 9).
- R4: A stop task (fast at 1, slow at 3) is accepted only in Starting or Started. It clears the run bit and the status word at the same edge, holds Stopping for one cycle, then enters Stopped. No started event follows a stop during Starting. In Stopped it has no effect.
- R5: The slow start task (address 2) is accepted in every state. It copies the select field (address 20, bits 1:0) into the copy register (address 21) and restarts the delay from Starting. The old status word stays until the new start completes. Later writes to the select field leave the copy unchanged.
- R6: A calibrate task (address 4) sets the calibration-done event (address 10) exactly CAL_CYC cycles after the task edge, whether or not the fast source runs.
- R7: Writing ones to address 12 ORs them into the enable mask, and writing ones to address 13 removes them. Both addresses read the mask. Bit 0 enables fast started, bit 1 slow started and bit 2 calibration done.
- R8: The interrupt output is high exactly while some event flag and its enable bit are both set.
- R9: Writing an event register loads bit 0 into the flag. A hardware set in the same cycle as a software write of 0 leaves the flag set.
- R10: Task registers read as 0. The debounce register keeps all 32 written bits.
- R11: Address 23 reads the fast state in bits 1:0 and the slow state in bits 3:2, coded Stopped=0, Starting=1, Started=2, Stopping=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 5 | Write word address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 5 | Read word address |
| reg_rdata_o | output | 32 | Read data for reg_raddr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Assertions check the following on every cycle:
- task guards in each state, and the one-cycle pass through Stopping;
- run bit kept consistent with the state;
- status and run cleared on an accepted stop;
- event set priority over software writes;
- mask arithmetic of the set and clear registers;
- calibration counter finishing only while busy.

Only the bench scenarios can show the following:
- the exact completion cycle of each delay;
- the source code that ends up in each status word;
- that a later select write does not disturb the copy;
- how enables gate the interrupt across sequences of events.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int SRC_W   = 2;
  localparam int SRC_POS = 16;
  localparam int NUM_EVT = 3;

  localparam int EVT_FAST = 0;
  localparam int EVT_SLOW = 1;
  localparam int EVT_CAL  = 2;

  localparam logic [SRC_W-1:0]  FAST_SRC_XTAL = 2'd1;
  localparam logic [DATA_W-1:0] DEB_RESET     = 32'h0000_0010;

  localparam logic [ADDR_W-1:0] RA_FAST_ON   = 5'd0;
  localparam logic [ADDR_W-1:0] RA_FAST_OFF  = 5'd1;
  localparam logic [ADDR_W-1:0] RA_SLOW_ON   = 5'd2;
  localparam logic [ADDR_W-1:0] RA_SLOW_OFF  = 5'd3;
  localparam logic [ADDR_W-1:0] RA_CALIB     = 5'd4;
  localparam logic [ADDR_W-1:0] RA_EV_FAST   = 5'd8;
  localparam logic [ADDR_W-1:0] RA_EV_SLOW   = 5'd9;
  localparam logic [ADDR_W-1:0] RA_EV_CAL    = 5'd10;
  localparam logic [ADDR_W-1:0] RA_IEN_SET   = 5'd12;
  localparam logic [ADDR_W-1:0] RA_IEN_CLR   = 5'd13;
  localparam logic [ADDR_W-1:0] RA_FAST_RUN  = 5'd16;
  localparam logic [ADDR_W-1:0] RA_FAST_STAT = 5'd17;
  localparam logic [ADDR_W-1:0] RA_SLOW_RUN  = 5'd18;
  localparam logic [ADDR_W-1:0] RA_SLOW_STAT = 5'd19;
  localparam logic [ADDR_W-1:0] RA_SLOW_SEL  = 5'd20;
  localparam logic [ADDR_W-1:0] RA_SLOW_COPY = 5'd21;
  localparam logic [ADDR_W-1:0] RA_DEBOUNCE  = 5'd22;
  localparam logic [ADDR_W-1:0] RA_PHASE     = 5'd23;

  typedef enum logic [1:0] {
    OSC_OFF  = 2'd0,
    OSC_RAMP = 2'd1,
    OSC_ON   = 2'd2,
    OSC_HALT = 2'd3
  } osc_state_e;

  function automatic logic [DATA_W-1:0] pack_stat(input logic on, input logic [SRC_W-1:0] src);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = on;
    w[SRC_POS +: SRC_W] = src;
    return w;
  endfunction

endpackage

// File: rtl/osc_fsm.sv
module osc_fsm
  import osc_ctl_pkg::*;
#(
  parameter int START_CYC   = 4,
  parameter bit GUARD_START = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [SRC_W-1:0] src_i,
  output osc_state_e       state_o,
  output logic             run_o,
  output logic             stat_on_o,
  output logic [SRC_W-1:0] stat_src_o,
  output logic             started_o
);

  localparam int CYC   = (START_CYC < 1) ? 1 : START_CYC;
  localparam int CNT_W = $clog2(CYC + 1);

  osc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             on_q, on_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             start_ok, stop_ok, done;

  generate
    if (GUARD_START) begin : g_guarded
      assign start_ok = start_i && (state_q == OSC_OFF || state_q == OSC_HALT);
    end else begin : g_free
      assign start_ok = start_i;
    end
  endgenerate

  assign stop_ok   = stop_i && (state_q == OSC_RAMP || state_q == OSC_ON);
  assign done      = (state_q == OSC_RAMP) && (cnt_q == CNT_W'(1));
  assign started_o = done && !stop_ok && !start_ok;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    on_d    = on_q;
    src_d   = src_q;
    if (stop_ok) begin
      state_d = OSC_HALT;
      run_d   = 1'b0;
      on_d    = 1'b0;
      src_d   = '0;
      cnt_d   = '0;
    end else if (start_ok) begin
      state_d = OSC_RAMP;
      run_d   = 1'b1;
      cnt_d   = CNT_W'(CYC);
    end else begin
      case (state_q)
        OSC_RAMP: begin
          if (done) begin
            state_d = OSC_ON;
            on_d    = 1'b1;
            src_d   = src_i;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        OSC_HALT: state_d = OSC_OFF;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OSC_OFF;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      on_q    <= 1'b0;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      on_q    <= on_d;
      src_q   <= src_d;
    end
  end

  assign state_o    = state_q;
  assign run_o      = run_q;
  assign stat_on_o  = on_q;
  assign stat_src_o = src_q;

  AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !stop_i && state_q == OSC_OFF |=> state_q == OSC_RAMP && run_q); // R2

  generate
    if (GUARD_START) begin : g_guard_chk
      AST_START_IGNORED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !stop_i && state_q == OSC_ON |=> state_q == OSC_ON && on_q); // R2
    end else begin : g_free_chk
      AST_RESTART_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !stop_i |=> state_q == OSC_RAMP && run_q); // R5
    end
  endgenerate

  AST_STARTED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    started_o |=> state_q == OSC_ON && on_q); // R3

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && (state_q == OSC_ON || state_q == OSC_RAMP) |=> state_q == OSC_HALT && !run_q && !on_q); // R4

  AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == OSC_HALT && !start_i |=> state_q == OSC_OFF); // R4

  AST_RUN_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q == (state_q == OSC_RAMP || state_q == OSC_ON)); // R4

endmodule

// File: rtl/osc_cal_timer.sv
module osc_cal_timer #(
  parameter int CAL_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic done_o
);

  localparam int CYC   = (CAL_CYC < 1) ? 1 : CAL_CYC;
  localparam int CNT_W = $clog2(CYC + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last   = busy_q && (cnt_q == CNT_W'(1));
  assign done_o = last && !go_i;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CYC);
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_CAL_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> busy_q); // R6

  AST_CAL_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q); // R6

endmodule

// File: rtl/osc_irq_ctrl.sv
module osc_irq_ctrl #(
  parameter int NEVT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] hw_set_i,
  input  logic [NEVT-1:0] sw_wr_i,
  input  logic            sw_val_i,
  input  logic            ien_set_i,
  input  logic            ien_clr_i,
  input  logic [NEVT-1:0] ien_data_i,
  output logic [NEVT-1:0] evt_o,
  output logic [NEVT-1:0] mask_o,
  output logic            irq_o
);

  logic [NEVT-1:0] evt_q, evt_d;
  logic [NEVT-1:0] mask_q, mask_d;

  generate
    for (genvar i = 0; i < NEVT; i++) begin : g_evt
      always_comb begin
        if (hw_set_i[i])      evt_d[i] = 1'b1;
        else if (sw_wr_i[i])  evt_d[i] = sw_val_i;
        else                  evt_d[i] = evt_q[i];
      end

      AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_i[i] |=> evt_q[i]); // R9

      AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_i[i] && !sw_val_i && !hw_set_i[i] |=> !evt_q[i]); // R9
    end
  endgenerate

  always_comb begin
    mask_d = mask_q;
    if (ien_set_i)      mask_d = mask_q | ien_data_i;
    else if (ien_clr_i) mask_d = mask_q & ~ien_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ien_set_i |=> (mask_q & $past(ien_data_i)) == $past(ien_data_i)); // R7

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr_i && !ien_set_i |=> (mask_q & $past(ien_data_i)) == '0); // R7

endmodule

// File: rtl/osc_task_ctrl.sv
module osc_task_ctrl
  import osc_ctl_pkg::*;
#(
  parameter int HF_START_CYC = 4,
  parameter int LF_START_CYC = 6,
  parameter int CAL_CYC      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  logic rst_meta_q, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  logic task_fast_on, task_fast_off, task_slow_on, task_slow_off, task_cal;
  logic [NUM_EVT-1:0] ev_wr;
  logic ien_set, ien_clr, sel_wr, deb_wr;

  always_comb begin
    task_fast_on  = reg_wr_i && reg_waddr_i == RA_FAST_ON  && reg_wdata_i[0];
    task_fast_off = reg_wr_i && reg_waddr_i == RA_FAST_OFF && reg_wdata_i[0];
    task_slow_on  = reg_wr_i && reg_waddr_i == RA_SLOW_ON  && reg_wdata_i[0];
    task_slow_off = reg_wr_i && reg_waddr_i == RA_SLOW_OFF && reg_wdata_i[0];
    task_cal      = reg_wr_i && reg_waddr_i == RA_CALIB    && reg_wdata_i[0];
    ev_wr[EVT_FAST] = reg_wr_i && reg_waddr_i == RA_EV_FAST;
    ev_wr[EVT_SLOW] = reg_wr_i && reg_waddr_i == RA_EV_SLOW;
    ev_wr[EVT_CAL]  = reg_wr_i && reg_waddr_i == RA_EV_CAL;
    ien_set = reg_wr_i && reg_waddr_i == RA_IEN_SET;
    ien_clr = reg_wr_i && reg_waddr_i == RA_IEN_CLR;
    sel_wr  = reg_wr_i && reg_waddr_i == RA_SLOW_SEL;
    deb_wr  = reg_wr_i && reg_waddr_i == RA_DEBOUNCE;
  end

  logic [SRC_W-1:0]  sel_q, sel_d, copy_q, copy_d;
  logic [DATA_W-1:0] deb_q, deb_d;

  always_comb begin
    sel_d  = sel_wr ? reg_wdata_i[SRC_W-1:0] : sel_q;
    copy_d = task_slow_on ? sel_q : copy_q;
    deb_d  = deb_wr ? reg_wdata_i : deb_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_q  <= '0;
      copy_q <= '0;
      deb_q  <= DEB_RESET;
    end else begin
      sel_q  <= sel_d;
      copy_q <= copy_d;
      deb_q  <= deb_d;
    end
  end

  osc_state_e       fast_state, slow_state;
  logic             fast_run, slow_run, fast_on, slow_on;
  logic [SRC_W-1:0] fast_src, slow_src;
  logic             fast_started, slow_started, cal_done;

  osc_fsm #(.START_CYC(HF_START_CYC), .GUARD_START(1'b1)) u_fast (
    .clk        (clk),
    .rst_n      (srst_n),
    .start_i    (task_fast_on),
    .stop_i     (task_fast_off),
    .src_i      (FAST_SRC_XTAL),
    .state_o    (fast_state),
    .run_o      (fast_run),
    .stat_on_o  (fast_on),
    .stat_src_o (fast_src),
    .started_o  (fast_started)
  );

  osc_fsm #(.START_CYC(LF_START_CYC), .GUARD_START(1'b0)) u_slow (
    .clk        (clk),
    .rst_n      (srst_n),
    .start_i    (task_slow_on),
    .stop_i     (task_slow_off),
    .src_i      (copy_q),
    .state_o    (slow_state),
    .run_o      (slow_run),
    .stat_on_o  (slow_on),
    .stat_src_o (slow_src),
    .started_o  (slow_started)
  );

  osc_cal_timer #(.CAL_CYC(CAL_CYC)) u_cal (
    .clk    (clk),
    .rst_n  (srst_n),
    .go_i   (task_cal),
    .done_o (cal_done)
  );

  logic [NUM_EVT-1:0] hw_set, evt, mask;

  always_comb begin
    hw_set = '0;
    hw_set[EVT_FAST] = fast_started;
    hw_set[EVT_SLOW] = slow_started;
    hw_set[EVT_CAL]  = cal_done;
  end

  osc_irq_ctrl #(.NEVT(NUM_EVT)) u_irq (
    .clk        (clk),
    .rst_n      (srst_n),
    .hw_set_i   (hw_set),
    .sw_wr_i    (ev_wr),
    .sw_val_i   (reg_wdata_i[0]),
    .ien_set_i  (ien_set),
    .ien_clr_i  (ien_clr),
    .ien_data_i (reg_wdata_i[NUM_EVT-1:0]),
    .evt_o      (evt),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_raddr_i)
      RA_EV_FAST:   reg_rdata_o[0] = evt[EVT_FAST];
      RA_EV_SLOW:   reg_rdata_o[0] = evt[EVT_SLOW];
      RA_EV_CAL:    reg_rdata_o[0] = evt[EVT_CAL];
      RA_IEN_SET,
      RA_IEN_CLR:   reg_rdata_o[NUM_EVT-1:0] = mask;
      RA_FAST_RUN:  reg_rdata_o[0] = fast_run;
      RA_FAST_STAT: reg_rdata_o = pack_stat(fast_on, fast_src);
      RA_SLOW_RUN:  reg_rdata_o[0] = slow_run;
      RA_SLOW_STAT: reg_rdata_o = pack_stat(slow_on, slow_src);
      RA_SLOW_SEL:  reg_rdata_o[SRC_W-1:0] = sel_q;
      RA_SLOW_COPY: reg_rdata_o[SRC_W-1:0] = copy_q;
      RA_DEBOUNCE:  reg_rdata_o = deb_q;
      RA_PHASE:     reg_rdata_o[3:0] = {slow_state, fast_state};
      default:      reg_rdata_o = '0;
    endcase
  end

  AST_DEBOUNCE_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    deb_wr |=> deb_q == $past(reg_wdata_i)); // R10

  AST_COPY_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    !task_slow_on |=> copy_q == $past(copy_q)); // R5

endmodule

// File: tb/tb_osc_task_ctrl.sv
`timescale 1ns/1ps
module tb_osc_task_ctrl;

  localparam int HF_D = 4;
  localparam int LF_D = 6;
  localparam int CA_D = 5;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2, OP_IRQ = 2'd3;

  localparam logic [4:0] A_HF_ON = 5'd0, A_HF_OFF = 5'd1, A_LF_ON = 5'd2, A_LF_OFF = 5'd3,
                         A_CAL = 5'd4, A_EV_HF = 5'd8, A_EV_LF = 5'd9, A_EV_CAL = 5'd10,
                         A_IEN_SET = 5'd12, A_IEN_CLR = 5'd13, A_HF_RUN = 5'd16,
                         A_HF_STAT = 5'd17, A_LF_RUN = 5'd18, A_LF_STAT = 5'd19,
                         A_LF_SEL = 5'd20, A_LF_COPY = 5'd21, A_DEB = 5'd22, A_PHASE = 5'd23;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 103;
  localparam vec_t VECS [NV] = '{
    // R7 enable mask set and clear
    '{OP_WR, 4'd7, A_IEN_SET, 32'h5, 32'h0},
    '{OP_RD, 4'd7, A_IEN_SET, 32'h0, 32'h5},
    '{OP_RD, 4'd7, A_IEN_CLR, 32'h0, 32'h5},
    '{OP_WR, 4'd7, A_IEN_CLR, 32'h4, 32'h0},
    '{OP_RD, 4'd7, A_IEN_SET, 32'h0, 32'h1},
    '{OP_RD, 4'd7, A_IEN_CLR, 32'h0, 32'h1},
    // R2 R3 R8 R11 fast start
    '{OP_WR, 4'd2, A_HF_ON, 32'h1, 32'h0},
    '{OP_RD, 4'd2, A_HF_RUN, 32'h0, 32'h1},
    '{OP_RD, 4'd11, A_PHASE, 32'h0, 32'h1},
    '{OP_RD, 4'd3, A_HF_STAT, 32'h0, 32'h0},
    '{OP_RD, 4'd3, A_EV_HF, 32'h0, 32'h0},
    '{OP_RD, 4'd3, A_HF_STAT, 32'h0, 32'h0001_0001},
    '{OP_RD, 4'd3, A_EV_HF, 32'h0, 32'h1},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h1},
    '{OP_RD, 4'd11, A_PHASE, 32'h0, 32'h2},
    // R2 start while Started ignored
    '{OP_WR, 4'd2, A_HF_ON, 32'h1, 32'h0},
    '{OP_RD, 4'd2, A_PHASE, 32'h0, 32'h2},
    '{OP_RD, 4'd2, A_HF_RUN, 32'h0, 32'h1},
    '{OP_RD, 4'd2, A_HF_STAT, 32'h0, 32'h0001_0001},
    // R9 software clear
    '{OP_WR, 4'd9, A_EV_HF, 32'h0, 32'h0},
    '{OP_RD, 4'd9, A_EV_HF, 32'h0, 32'h0},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h0},
    // R4 fast stop from Started
    '{OP_WR, 4'd4, A_HF_OFF, 32'h1, 32'h0},
    '{OP_RD, 4'd4, A_PHASE, 32'h0, 32'h3},
    '{OP_RD, 4'd4, A_PHASE, 32'h0, 32'h0},
    '{OP_RD, 4'd4, A_HF_RUN, 32'h0, 32'h0},
    '{OP_RD, 4'd4, A_HF_STAT, 32'h0, 32'h0},
    // R4 stop while Stopped ignored
    '{OP_WR, 4'd4, A_HF_OFF, 32'h1, 32'h0},
    '{OP_RD, 4'd4, A_PHASE, 32'h0, 32'h0},
    '{OP_RD, 4'd4, A_HF_RUN, 32'h0, 32'h0},
    // R10 task regs read zero, debounce full width
    '{OP_RD, 4'd10, A_HF_ON, 32'h0, 32'h0},
    '{OP_RD, 4'd10, A_CAL, 32'h0, 32'h0},
    '{OP_WR, 4'd10, A_DEB, 32'hA5A5_01A5, 32'h0},
    '{OP_RD, 4'd10, A_DEB, 32'h0, 32'hA5A5_01A5},
    // R5 R3 slow start with source copy
    '{OP_WR, 4'd5, A_LF_SEL, 32'h6, 32'h0},
    '{OP_RD, 4'd5, A_LF_SEL, 32'h0, 32'h2},
    '{OP_WR, 4'd5, A_LF_ON, 32'h1, 32'h0},
    '{OP_RD, 4'd5, A_LF_RUN, 32'h0, 32'h1},
    '{OP_RD, 4'd5, A_LF_COPY, 32'h0, 32'h2},
    '{OP_WR, 4'd5, A_LF_SEL, 32'h1, 32'h0},
    '{OP_RD, 4'd5, A_LF_COPY, 32'h0, 32'h2},
    '{OP_RD, 4'd11, A_PHASE, 32'h0, 32'h4},
    '{OP_RD, 4'd3, A_LF_STAT, 32'h0, 32'h0},
    '{OP_RD, 4'd3, A_LF_STAT, 32'h0, 32'h0002_0001},
    '{OP_RD, 4'd3, A_EV_LF, 32'h0, 32'h1},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h0},
    '{OP_WR, 4'd7, A_IEN_SET, 32'h2, 32'h0},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h1},
    '{OP_WR, 4'd7, A_IEN_CLR, 32'h2, 32'h0},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h0},
    '{OP_WR, 4'd9, A_EV_LF, 32'h0, 32'h0},
    // R5 slow restart while Started
    '{OP_WR, 4'd5, A_LF_ON, 32'h1, 32'h0},
    '{OP_RD, 4'd5, A_PHASE, 32'h0, 32'h4},
    '{OP_RD, 4'd5, A_LF_COPY, 32'h0, 32'h1},
    '{OP_RD, 4'd5, A_LF_STAT, 32'h0, 32'h0002_0001},
    '{OP_IDLE, 4'd5, 5'd0, 32'd3, 32'h0},
    '{OP_RD, 4'd5, A_LF_STAT, 32'h0, 32'h0001_0001},
    '{OP_RD, 4'd11, A_PHASE, 32'h0, 32'h8},
    // R4 slow stop during Starting
    '{OP_WR, 4'd9, A_EV_LF, 32'h0, 32'h0},
    '{OP_WR, 4'd4, A_LF_ON, 32'h1, 32'h0},
    '{OP_WR, 4'd4, A_LF_OFF, 32'h1, 32'h0},
    '{OP_RD, 4'd4, A_PHASE, 32'h0, 32'hC},
    '{OP_RD, 4'd4, A_PHASE, 32'h0, 32'h0},
    '{OP_RD, 4'd4, A_LF_RUN, 32'h0, 32'h0},
    '{OP_RD, 4'd4, A_LF_STAT, 32'h0, 32'h0},
    '{OP_IDLE, 4'd4, 5'd0, 32'd8, 32'h0},
    '{OP_RD, 4'd4, A_EV_LF, 32'h0, 32'h0},
    // R6 calibration with fast source stopped
    '{OP_WR, 4'd6, A_CAL, 32'h1, 32'h0},
    '{OP_RD, 4'd6, A_EV_CAL, 32'h0, 32'h0},
    '{OP_IDLE, 4'd6, 5'd0, 32'd3, 32'h0},
    '{OP_RD, 4'd6, A_EV_CAL, 32'h0, 32'h0},
    '{OP_RD, 4'd6, A_EV_CAL, 32'h0, 32'h1},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h0},
    '{OP_WR, 4'd7, A_IEN_SET, 32'h4, 32'h0},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h1},
    '{OP_WR, 4'd9, A_EV_CAL, 32'h0, 32'h0},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h0},
    // R9 software set
    '{OP_WR, 4'd9, A_EV_CAL, 32'h1, 32'h0},
    '{OP_RD, 4'd9, A_EV_CAL, 32'h0, 32'h1},
    '{OP_IRQ, 4'd8, 5'd0, 32'h0, 32'h1},
    '{OP_WR, 4'd9, A_EV_CAL, 32'h0, 32'h0},
    // R4 fast stop during Starting
    '{OP_WR, 4'd4, A_HF_ON, 32'h1, 32'h0},
    '{OP_WR, 4'd4, A_HF_OFF, 32'h1, 32'h0},
    '{OP_RD, 4'd4, A_PHASE, 32'h0, 32'h3},
    '{OP_RD, 4'd4, A_HF_RUN, 32'h0, 32'h0},
    '{OP_IDLE, 4'd4, 5'd0, 32'd6, 32'h0},
    '{OP_RD, 4'd4, A_EV_HF, 32'h0, 32'h0},
    '{OP_RD, 4'd4, A_HF_STAT, 32'h0, 32'h0},
    // R2 restart from Stopping
    '{OP_WR, 4'd2, A_HF_ON, 32'h1, 32'h0},
    '{OP_WR, 4'd2, A_HF_OFF, 32'h1, 32'h0},
    '{OP_WR, 4'd2, A_HF_ON, 32'h1, 32'h0},
    '{OP_RD, 4'd2, A_PHASE, 32'h0, 32'h1},
    '{OP_RD, 4'd2, A_HF_RUN, 32'h0, 32'h1},
    '{OP_IDLE, 4'd2, 5'd0, 32'd2, 32'h0},
    '{OP_RD, 4'd3, A_HF_STAT, 32'h0, 32'h0001_0001},
    '{OP_RD, 4'd3, A_EV_HF, 32'h0, 32'h1},
    // R9 hardware set beats software clear in the same cycle
    '{OP_WR, 4'd9, A_HF_OFF, 32'h1, 32'h0},
    '{OP_WR, 4'd9, A_EV_HF, 32'h0, 32'h0},
    '{OP_WR, 4'd9, A_HF_ON, 32'h1, 32'h0},
    '{OP_IDLE, 4'd9, 5'd0, 32'd3, 32'h0},
    '{OP_WR, 4'd9, A_EV_HF, 32'h0, 32'h0},
    '{OP_RD, 4'd9, A_EV_HF, 32'h0, 32'h1},
    '{OP_RD, 4'd9, A_HF_STAT, 32'h0, 32'h0001_0001}
  };

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [4:0]  reg_raddr;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  osc_task_ctrl #(.HF_START_CYC(HF_D), .LF_START_CYC(LF_D), .CAL_CYC(CA_D)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_waddr_i (reg_waddr),
    .reg_wdata_i (reg_wdata),
    .reg_raddr_i (reg_raddr),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_raddr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_waddr = a;
    reg_wdata = d;
  endtask

  task automatic reset_checks(input string when);
    rd_chk({"R1 phase ", when}, A_PHASE, 32'h0);
    rd_chk({"R1 fast run ", when}, A_HF_RUN, 32'h0);
    rd_chk({"R1 fast stat ", when}, A_HF_STAT, 32'h0);
    rd_chk({"R1 slow stat ", when}, A_LF_STAT, 32'h0);
    rd_chk({"R1 mask ", when}, A_IEN_SET, 32'h0);
    rd_chk({"R1 fast event ", when}, A_EV_HF, 32'h0);
    rd_chk({"R1 cal event ", when}, A_EV_CAL, 32'h0);
    rd_chk({"R1 debounce ", when}, A_DEB, 32'h10);
    check({"R1 irq ", when}, {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired (R1 run did not complete)");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_waddr = '0;
    reg_wdata = '0;
    reg_raddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reset_checks("after power-up");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      case (VECS[k].op)
        OP_WR: begin
          reg_wr = 1'b1;
          reg_waddr = VECS[k].addr;
          reg_wdata = VECS[k].data;
        end
        OP_RD: begin
          reg_raddr = VECS[k].addr;
          #1;
          check($sformatf("R%0d vector %0d addr %0d", VECS[k].req, k, VECS[k].addr),
                reg_rdata, VECS[k].exp);
        end
        OP_IDLE: begin
          for (int j = 1; j < int'(VECS[k].data); j++) @(negedge clk);
        end
        default: begin
          #1;
          check($sformatf("R%0d vector %0d irq", VECS[k].req, k), {31'b0, irq}, VECS[k].exp);
        end
      endcase
    end

    // R1 reset in the middle of a start with an interrupt pending
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    check("R8 irq before mid-run reset", {31'b0, irq}, 32'h1);
    wr(A_HF_OFF, 32'h1);
    wr(A_HF_ON, 32'h1);
    @(negedge clk);
    reg_wr = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reset_checks("after mid-run reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule